// File: doc/BRIEF.md
# Reset Time-Out Sequencer

This block keeps the processor core in reset after a reset event until the required settling delays have elapsed, then lets it run. Two delays are available. The first is a power-up timer, counted in ticks of a slow, independent timer oscillator. The second is an oscillator start-up timer, counted in cycles of the main oscillator clock. They always run one after the other: the power-up timer first, then the start-up timer.

The reset cause decides which delays are used. The causes are power-on, brown-out and wake from sleep. The oscillator mode and the power-up timer enable also decide this. RC mode never waits for oscillator start-up. A wake from sleep never uses the power-up timer.

The delays are timed from the power-on pulse and not from master clear. A master clear held low past the delays therefore releases the core the moment it rises. The phase output shows which delay is currently running.

Top module: `reset_timeout_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 and `phase_o` reads 1 (power-on hold). Raising `por_i` in the middle of a sequence restarts the sequence from the start, including both full delays.
- R2: The power-up timer phase (`phase_o` = 2) lasts exactly `PWRT_TICKS` clock edges on which `tick_i` is high. No other edges count.
- R3: The start-up timer phase (`phase_o` = 3) lasts exactly `OST_CYCLES` clock cycles.
- R4: `osc_mode_i` is encoded as 00 LP, 01 XT, 10 HS, 11 RC. After power-on the order is hold, then the power-up timer (only if `pwrt_en_i` is 1), then the start-up timer (only if the mode is not RC), then running. The start-up timer never comes before the power-up timer.
- R5: In RC mode with `pwrt_en_i` at 0, the phase becomes 0 on the first clock edge after `por_i` falls.
- R6: A one-cycle `bor_i` pulse while the core is running starts the same delay sequence as power-on, chosen by the same mode and enable.
- R7: A one-cycle `wake_i` pulse while the core is running gives a start-up timer only in the LP, XT and HS modes. In RC mode it gives no delay. `pwrt_en_i` has no effect on a wake.
- R8: `wake_i` pulses while a delay is running have no effect: that sequence's timer lengths stay unchanged.
- R9: While `mclr_n_i` is low, `core_rst_o` stays 1 and the timers still run to completion. If they have already expired, raising `mclr_n_i` drops `core_rst_o` with no clock edge needed.
- R10: `core_rst_o` is 0 exactly when `phase_o` is 0 (running) and `mclr_n_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on pulse; high while the power-on delay is in progress |
| mclr_n_i | input | 1 | External master clear, active low |
| bor_i | input | 1 | Brown-out event |
| wake_i | input | 1 | Wake-from-sleep request |
| osc_mode_i | input | 2 | Oscillator mode: 00 LP, 01 XT, 10 HS, 11 RC |
| pwrt_en_i | input | 1 | Power-up timer enable |
| tick_i | input | 1 | One-cycle tick from the slow timer oscillator |
| core_rst_o | output | 1 | Reset to the core, active high |
| phase_o | output | 2 | 0 running, 1 power-on hold, 2 power-up timer, 3 start-up timer |

## Verification
A wrong state shows at the ports right away, because `phase_o` mirrors the state register and `core_rst_o` depends on it through one gate.

A counter fault shows up at the end of the sequence, when the phase changes early or late. The bench counts the ticks and cycles spent in each phase, so an off-by-one in either timer becomes a length mismatch.

A wrong decision after an event shows on the next clock edge, as a phase that should not appear or a missing one. This covers a skipped timer, a start-up timer in RC mode, or a wake that restarts a delay.

// File: rtl/reset_timeout_seq.sv
module reset_timeout_seq #(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       mclr_n_i,
  input  logic       bor_i,
  input  logic       wake_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  input  logic       tick_i,
  output logic       core_rst_o,
  output logic [1:0] phase_o
);

  localparam int TW = $clog2(PWRT_TICKS + 1);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [1:0] MODE_RC = 2'b11;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_POR  = 2'd1,
    PH_PWRT = 2'd2,
    PH_OST  = 2'd3
  } phase_t;

  phase_t st, st_nx, after_pwrt, after_event;
  logic [TW-1:0] tk_cnt;
  logic [CW-1:0] osc_cnt;
  logic is_rc, pwrt_done, ost_done, restart;

  assign is_rc       = (osc_mode_i == MODE_RC);
  assign after_pwrt  = is_rc ? PH_RUN : PH_OST;
  assign after_event = pwrt_en_i ? PH_PWRT : after_pwrt;
  assign pwrt_done   = tick_i && (tk_cnt == TW'(PWRT_TICKS - 1));
  assign ost_done    = (osc_cnt == CW'(OST_CYCLES - 1));

  always_comb begin
    st_nx = st;
    if (por_i)
      st_nx = PH_POR;
    else if (bor_i)
      st_nx = after_event;
    else begin
      case (st)
        PH_POR:  st_nx = after_event;
        PH_PWRT: if (pwrt_done) st_nx = after_pwrt;
        PH_OST:  if (ost_done) st_nx = PH_RUN;
        default: if (wake_i) st_nx = after_pwrt;
      endcase
    end
  end

  assign restart = por_i || bor_i || (st_nx != st);

  always_ff @(posedge clk_i) begin
    st <= st_nx;
    if (restart)
      tk_cnt <= '0;
    else if (st == PH_PWRT && tick_i)
      tk_cnt <= tk_cnt + 1'b1;
    if (restart)
      osc_cnt <= '0;
    else if (st == PH_OST)
      osc_cnt <= osc_cnt + 1'b1;
  end

  assign phase_o    = st;
  assign core_rst_o = (st != PH_RUN) || !mclr_n_i;

  assert_pwrt_hold_R2: assert property (@(posedge clk_i) disable iff (por_i)
    (st == PH_PWRT && !tick_i && !bor_i) |=> st == PH_PWRT);

  assert_ost_hold_R3: assert property (@(posedge clk_i) disable iff (por_i)
    (st == PH_OST && !bor_i && osc_cnt != CW'(OST_CYCLES - 1)) |=> st == PH_OST);

  assert_ost_order_R4: assert property (@(posedge clk_i) disable iff (por_i)
    (st == PH_OST && !bor_i) |=> st != PH_PWRT);

  assert_no_ost_rc_R4: assert property (@(posedge clk_i) disable iff (por_i)
    (st != PH_OST && is_rc) |=> st != PH_OST);

  assert_rc_wake_R7: assert property (@(posedge clk_i) disable iff (por_i)
    (st == PH_RUN && is_rc && !bor_i) |=> st == PH_RUN);

  assert_wake_no_pwrt_R7: assert property (@(posedge clk_i) disable iff (por_i)
    (st == PH_RUN && !bor_i) |=> st != PH_PWRT);

endmodule

// File: tb/reset_timeout_seq_tb_top.sv
module reset_timeout_seq_tb_top;
  localparam int NT = 5;
  localparam int NO = 16;

  logic clk = 0;
  logic por_i = 1, mclr_n_i = 1, bor_i = 0, wake_i = 0, pwrt_en_i = 0, tick_i = 0;
  logic [1:0] osc_mode_i = 2'b00;
  logic core_rst_o;
  logic [1:0] phase_o;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  reset_timeout_seq #(.PWRT_TICKS(NT), .OST_CYCLES(NO)) dut_i (
    .clk_i(clk), .por_i(por_i), .mclr_n_i(mclr_n_i), .bor_i(bor_i),
    .wake_i(wake_i), .osc_mode_i(osc_mode_i), .pwrt_en_i(pwrt_en_i),
    .tick_i(tick_i), .core_rst_o(core_rst_o), .phase_o(phase_o));

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    tick_i = (cyc % 3 == 0);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(output int pt, output int oc, output int steps,
                         output int order_ok, output int rst_ok, input bit poke_wake);
    bit seen_ost = 0;
    pt = 0; oc = 0; steps = 0; order_ok = 1; rst_ok = 1;
    while (phase_o != 2'd0 && steps < 5000) begin
      if (phase_o == 2'd2 && tick_i) pt++;
      if (phase_o == 2'd2 && seen_ost) order_ok = 0;
      if (phase_o == 2'd3) begin oc++; seen_ost = 1; end
      if (core_rst_o !== 1'b1) rst_ok = 0;
      wake_i = poke_wake && (steps == 2);
      step();
      steps++;
    end
    wake_i = 0;
  endtask

  task automatic power_on(input int m, input int en);
    osc_mode_i = 2'(m); pwrt_en_i = 1'(en);
    por_i = 1; step(); step();
    chk("R1 hold phase", phase_o, 1);
    chk("R1 hold reset", core_rst_o, 1);
    por_i = 0;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pt, oc, st, ok, rk;
    step(); step();
    chk("R1 reset state phase", phase_o, 1);
    chk("R10 reset state rst", core_rst_o, 1);

    for (int m = 0; m < 4; m++) begin
      for (int en = 0; en < 2; en++) begin
        power_on(m, en);
        run_seq(pt, oc, st, ok, rk, 0);
        chk("R2 powerup ticks", pt, en ? NT : 0);
        chk("R3 powerup ost cycles", oc, (m != 3) ? NO : 0);
        chk("R4 powerup order", ok, 1);
        chk("R10 reset during delay", rk, 1);
        if (m == 3 && en == 0) chk("R5 no timeout", st, 1);
        step();
        chk("R10 released", core_rst_o, 0);

        bor_i = 1; step(); bor_i = 0;
        run_seq(pt, oc, st, ok, rk, 0);
        chk("R6 brownout ticks", pt, en ? NT : 0);
        chk("R6 brownout ost cycles", oc, (m != 3) ? NO : 0);
        chk("R6 brownout order", ok, 1);

        wake_i = 1; step(); wake_i = 0;
        run_seq(pt, oc, st, ok, rk, 0);
        chk("R7 wake ticks", pt, 0);
        chk("R7 wake ost cycles", oc, (m != 3) ? NO : 0);
        if (m == 3) chk("R7 rc wake reset", core_rst_o, 0);
      end
    end

    power_on(1, 1);
    run_seq(pt, oc, st, ok, rk, 1);
    chk("R8 wake ignored ticks", pt, NT);
    chk("R8 wake ignored ost", oc, NO);

    power_on(2, 1);
    for (int i = 0; i < 200 && phase_o != 2'd3; i++) step();
    for (int i = 0; i < 4; i++) step();
    por_i = 1; step();
    chk("R1 restart phase", phase_o, 1);
    step(); por_i = 0;
    run_seq(pt, oc, st, ok, rk, 0);
    chk("R1 restart ticks", pt, NT);
    chk("R1 restart ost", oc, NO);

    mclr_n_i = 0;
    power_on(0, 1);
    run_seq(pt, oc, st, ok, rk, 0);
    chk("R9 timers run ticks", pt, NT);
    chk("R9 timers run ost", oc, NO);
    for (int i = 0; i < 5; i++) step();
    chk("R9 held phase", phase_o, 0);
    chk("R9 held reset", core_rst_o, 1);
    mclr_n_i = 1;
    #1;
    chk("R9 immediate release", core_rst_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule